// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Live Parity Selection

This block turns a parallel data word into one asynchronous serial frame on a single output line. A frame begins when a one-cycle start pulse is seen while the block is idle. The frame is a low start bit, the data bits least significant first, an optional parity bit and one high stop bit. Two live inputs decide whether the parity bit is present and whether it gives even or odd parity. The block copies the word and both settings at the moment the frame is accepted, so the inputs may change freely once the frame is under way.

The clock frequency, the baud rate and the number of data bits are parameters. Every bit is held on the line for the same number of clock cycles, and that count is the clock frequency divided by the baud rate, rounded to the nearest integer. The busy output covers the whole frame, and the block can take a new frame in the first cycle that busy is low again.

The controller has five states. IDLE holds the line high, and a start pulse moves it to START (accept). START drives the line low for one bit period and then moves to DATA (start done). DATA sends one data bit per bit period. After the last data bit it moves to PARITY when parity was enabled at accept (data done, parity on), or straight to STOP (data done, parity off). PARITY sends the parity bit for one period and then moves to STOP (parity done). STOP drives the line high for one period and then returns to IDLE (frame done).

Top module: `uart_frame_tx`

## Requirements
- R1: After reset, and whenever `busy_o` is low, `tx_o` is high and `busy_o` is 0.
- R2: A high `start_i` seen at a clock edge while idle starts a frame. From that edge `busy_o` is 1 and `tx_o` is 0 for one bit period (the start bit).
- R3: The data bits follow the start bit, bit 0 of the captured word first and the top bit last, one bit period each.
- R4: One bit period lasts round(CLK_HZ / BAUD) clock cycles, with halves rounded up. With CLK_HZ = 1000 and BAUD = 130 that is 8 cycles.
- R5: When `par_en_i` = 1 at accept, one parity bit follows the last data bit. With `par_odd_i` = 0 the count of ones across the data and parity bits is even. With `par_odd_i` = 1 that count is odd.
- R6: When `par_en_i` = 0 at accept, no parity bit is sent and the stop bit follows the last data bit directly.
- R7: The stop bit is high for one bit period. `busy_o` is high for exactly (frame bits × bit period) cycles and is low in the cycle after the stop period ends.
- R8: The data word, `par_en_i` and `par_odd_i` are captured at accept. Changes to them during a frame have no effect on that frame.
- R9: A start pulse that arrives while `busy_o` is high is ignored. It changes nothing in the current frame and does not produce a later frame.
- R10: A start pulse given in the first cycle that `busy_o` is low is accepted, so frames can follow each other with a single idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | One-cycle request to send `data_i` |
| data_i | input | DATA_BITS | Word to send, sampled at accept |
| par_en_i | input | 1 | 1 adds a parity bit, sampled at accept |
| par_odd_i | input | 1 | 0 selects even parity, 1 selects odd, sampled at accept |
| tx_o | output | 1 | Serial line, high when idle |
| busy_o | output | 1 | High while a frame is being sent |

## Verification
On every cycle the assertions check the following:
- The line is high whenever the block is idle and during the stop state.
- The first busy cycle drives a start bit.
- The cycle before busy falls is high.
- The captured parity settings hold steady for the whole frame.
- The parity state is reached only when parity was enabled.
- The bit-period counter never passes its rounded limit.

Some behaviours only the bench scenarios can show, because they depend on comparing the line with a frame worked out independently:
- The exact bit order and the parity value for each sense.
- The rounded bit length.
- That inputs changed in mid-frame and start pulses given while busy leave no trace.
- That a back-to-back request is taken in the first idle cycle.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    // Nearest-integer division, halves rounded up.
    function automatic int unsigned round_div(input int unsigned num, input int unsigned den);
        return (num + den / 2) / den;
    endfunction

endpackage

// File: rtl/uart_bit_timer.sv
module uart_bit_timer #(
    parameter int unsigned CYCLES = 434
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic tick
);
    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run || tick)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end

    assign tick = run && (cnt_q == LAST);

    AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST); // R4

endmodule

// File: rtl/uart_parity_gen.sv
module uart_parity_gen #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] data_i,
    input  logic             odd_i,
    output logic             par_o
);
    // Even: the parity bit equals the XOR of the data.
    // Odd: the parity bit is that XOR inverted.
    assign par_o = (^data_i) ^ odd_i;

endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             shift,
    input  logic [WIDTH-1:0] din,
    output logic             bit_o
);
    logic [WIDTH-1:0] q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            q <= '0;
        else if (load)
            q <= din;
        else if (shift)
            q <= q >> 1;
    end

    assign bit_o = q[0];

endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uart_tx_pkg::*;
#(
    parameter int unsigned CLK_HZ    = 50_000_000,
    parameter int unsigned BAUD      = 115_200,
    parameter int unsigned DATA_BITS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 start_i,
    input  logic [DATA_BITS-1:0] data_i,
    input  logic                 par_en_i,
    input  logic                 par_odd_i,
    output logic                 tx_o,
    output logic                 busy_o
);
    localparam int unsigned BIT_CYC = round_div(CLK_HZ, BAUD);
    localparam int unsigned IDX_W   = (DATA_BITS > 1) ? $clog2(DATA_BITS) : 1;
    localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DATA_BITS - 1);

    tx_state_e        state_q, state_d;
    logic             tick;
    logic             accept;
    logic             last_data;
    logic [IDX_W-1:0] bit_idx_q;
    logic             par_en_q;
    logic             par_bit_q;
    logic             par_calc;
    logic             shift_bit;

    assign accept    = (state_q == ST_IDLE) && start_i;
    assign last_data = (bit_idx_q == IDX_LAST);

    uart_bit_timer #(.CYCLES(BIT_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .tick  (tick)
    );

    uart_parity_gen #(.WIDTH(DATA_BITS)) u_par (
        .data_i (data_i),
        .odd_i  (par_odd_i),
        .par_o  (par_calc)
    );

    uart_tx_shifter #(.WIDTH(DATA_BITS)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (accept),
        .shift ((state_q == ST_DATA) && tick),
        .din   (data_i),
        .bit_o (shift_bit)
    );

    // State register and the registers captured with it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            bit_idx_q <= '0;
            par_en_q  <= 1'b0;
            par_bit_q <= 1'b0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                bit_idx_q <= '0;
                par_en_q  <= par_en_i;
                par_bit_q <= par_calc;
            end else if ((state_q == ST_DATA) && tick && !last_data) begin
                bit_idx_q <= bit_idx_q + 1'b1;
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_START;
            ST_START: if (tick) state_d = ST_DATA;
            ST_DATA:  if (tick && last_data) state_d = par_en_q ? ST_PAR : ST_STOP;
            ST_PAR:   if (tick) state_d = ST_STOP;
            ST_STOP:  if (tick) state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        busy_o = 1'b1;
        tx_o   = 1'b1;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_START: tx_o = 1'b0;
            ST_DATA:  tx_o = shift_bit;
            ST_PAR:   tx_o = par_bit_q;
            ST_STOP:  tx_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> tx_o); // R1

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> !tx_o); // R2

    AST_PAR_ONLY_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAR) |-> par_en_q); // R6

    AST_STOP_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP) |-> tx_o); // R7

    AST_END_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> $past(tx_o)); // R7

    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o)) |-> ($stable(par_en_q) && $stable(par_bit_q))); // R8

endmodule

// File: tb/sim_uart_frame_tx.sv
`timescale 1ns/1ps
module sim_uart_frame_tx;
    localparam int CLK_HZ = 1000;
    localparam int BAUD   = 130;
    localparam int NB     = 8;
    localparam int P      = 8;   // 1000/130 = 7.69, nearest is 8

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [NB-1:0] data_i = '0;
    logic          par_en_i = 1'b0;
    logic          par_odd_i = 1'b0;
    logic          tx_o;
    logic          busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    bit mon_on = 1'b0;

    logic [15:0] q_bits[$];
    int          q_len[$];
    string       q_tag[$];

    always #2.5 clk = ~clk;

    uart_frame_tx #(.CLK_HZ(CLK_HZ), .BAUD(BAUD), .DATA_BITS(NB)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .data_i(data_i),
        .par_en_i(par_en_i), .par_odd_i(par_odd_i), .tx_o(tx_o), .busy_o(busy_o)
    );

    // Driver: called just after a falling edge; pushes the expected frame
    task automatic send(input logic [NB-1:0] d, input logic pe, input logic po,
                        input string tag, input bit expect_frame);
        logic [15:0] b;
        int          n;
        start_i = 1'b1; data_i = d; par_en_i = pe; par_odd_i = po;
        if (expect_frame) begin
            b = '0;
            b[0] = 1'b0;
            for (int i = 0; i < NB; i++) b[1+i] = d[i];
            n = NB + 1;
            if (pe) begin
                b[n] = po ? ~(^d) : (^d);
                n++;
            end
            b[n] = 1'b1;
            n++;
            q_bits.push_back(b); q_len.push_back(n); q_tag.push_back(tag);
        end
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy_o) @(negedge clk);
    endtask

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    // Monitor: compares the line against the queued frame on every cycle
    logic [15:0] cur_bits;
    int          cur_len, cyc;
    string       cur_tag;
    bit          in_frame = 1'b0, stray = 1'b0, bit_bad = 1'b0;
    logic        bad_act;

    always @(negedge clk) begin
        if (mon_on) begin
            if (!busy_o) stray = 1'b0;
            if (!in_frame && busy_o && !stray) begin
                if (q_len.size() == 0) begin
                    stray = 1'b1;
                    n_cmp++; n_bad++;
                    $display("FAIL R9 unexpected frame: busy actual 1 expected 0");
                end else begin
                    cur_bits = q_bits.pop_front();
                    cur_len  = q_len.pop_front();
                    cur_tag  = q_tag.pop_front();
                    in_frame = 1'b1; cyc = 0; bit_bad = 1'b0;
                end
            end
            if (in_frame) begin
                if (cyc < cur_len * P) begin
                    if (!bit_bad && (tx_o !== cur_bits[cyc / P] || busy_o !== 1'b1)) begin
                        bit_bad = 1'b1;
                        bad_act = tx_o;
                    end
                    if (cyc % P == P - 1) begin
                        n_cmp++;
                        if (bit_bad) begin
                            n_bad++;
                            $display("FAIL %s bit %0d: tx actual %b expected %b (busy %b)",
                                     cur_tag, cyc / P, bad_act, cur_bits[cyc / P], busy_o);
                        end
                        bit_bad = 1'b0;
                    end
                    cyc++;
                end else begin
                    n_cmp++;
                    if (busy_o !== 1'b0) begin
                        n_bad++;
                        $display("FAIL R7 busy after stop: actual %b expected 0", busy_o);
                    end
                    in_frame = 1'b0;
                end
            end
        end
    end

    initial begin
        #(5.0 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: run did not end, actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(tx_o === 1'b1, "R1 reset tx", tx_o, 1);
        check(busy_o === 1'b0, "R1 reset busy", busy_o, 0);
        mon_on = 1'b1;

        // Plain frames, no parity (R2 R3 R4 R6)
        send(8'hA5, 1'b0, 1'b0, "R2 R3 R4 R6 A5", 1'b1); wait_idle(); repeat (3) @(negedge clk);
        send(8'hFF, 1'b0, 1'b0, "R3 R6 FF", 1'b1);       wait_idle(); repeat (3) @(negedge clk);
        // Parity senses (R5)
        send(8'h3C, 1'b1, 1'b0, "R5 even 3C", 1'b1); wait_idle(); repeat (2) @(negedge clk);
        send(8'h3D, 1'b1, 1'b0, "R5 even 3D", 1'b1); wait_idle(); repeat (2) @(negedge clk);
        send(8'h3D, 1'b1, 1'b1, "R5 odd 3D", 1'b1);  wait_idle(); repeat (2) @(negedge clk);
        send(8'h00, 1'b1, 1'b1, "R5 odd 00", 1'b1);  wait_idle(); repeat (2) @(negedge clk);

        // Inputs changed mid-frame (R8)
        send(8'h81, 1'b1, 1'b0, "R8 81", 1'b1);
        data_i = 8'h7E; par_en_i = 1'b0; par_odd_i = 1'b1;
        repeat (30) @(negedge clk);
        data_i = 8'h01; par_en_i = 1'b1;
        wait_idle(); repeat (3) @(negedge clk);

        // Start while busy (R9)
        send(8'h55, 1'b0, 1'b0, "R9 55", 1'b1);
        repeat (20) @(negedge clk);
        send(8'hF0, 1'b1, 1'b1, "", 1'b0);
        repeat (30) @(negedge clk);
        send(8'h0F, 1'b1, 1'b0, "", 1'b0);
        wait_idle(); repeat (5) @(negedge clk);
        check(busy_o === 1'b0, "R9 busy after ignored start", busy_o, 0);
        check(q_len.size() == 0, "R9 pending frames", q_len.size(), 0);

        // Back-to-back (R10)
        send(8'h12, 1'b1, 1'b1, "R10 first 12", 1'b1);
        wait_idle();
        send(8'h34, 1'b1, 1'b0, "R10 second 34", 1'b1);
        wait_idle();
        send(8'hC6, 1'b0, 1'b0, "R10 third C6", 1'b1);
        wait_idle();

        repeat (20) @(negedge clk);
        check(busy_o === 1'b0, "R1 final idle busy", busy_o, 0);
        check(tx_o === 1'b1, "R1 final idle line", tx_o, 1);
        check(q_len.size() == 0, "R10 all frames seen", q_len.size(), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule